// File: doc/BRIEF.md
# ADC Peak Level Meter

This block watches the sample streams of four audio ADC channels and keeps, for each one, the largest sample magnitude seen since that channel was last read. Samples are signed two's complement words, each qualified by its own valid strobe. The raw samples are metered before any offset-removal stage. A constant DC offset therefore raises the measured level.

Software reads a channel through a small register port made of an address, a read strobe and a read-data word. The held magnitude is turned into a decibel code by a ladder of comparators. The thresholds are spaced one decibel apart below full scale. The returned word gives the attenuation from full scale in whole decibels, from 0 down to a floor of 60. A read returns the level gathered so far and clears that channel, so the next reading covers only the time since this one.

Top module: `peak_level_meter`

## Requirements
- R1: After reset the read-data word is 0 and every channel's held peak is empty, so a first read of any channel returns 60.
- R2: Each channel's held peak is the largest magnitude among the samples accepted while its valid strobe was high since its last read. Samples with valid low have no effect. Samples are metered raw, so a repeated constant positive value is reported at its own level.
- R3: A later sample of smaller magnitude never lowers a held peak; the peak is kept until its channel is read.
- R4: Channel i is read at address BASE_ADDR+i. A read clears only the addressed channel, and the other channels keep their peaks.
- R5: The read word has bits [CODE_W-1:6] at zero. Its low bits give the attenuation in whole dB: the number of thresholds FS*10^(-k/20), for k = 0..60 with FS = 2^(SAMPLE_W-1)-1, that the peak lies strictly below. A full-scale peak reads 0, and a peak between -(k-1) dB and -k dB reads k.
- R6: A peak below -60 dB, including zero, reads 60. No code above 60 is ever returned.
- R7: The magnitude of the most negative sample (only the sign bit set) is taken as FS, so that sample reads 0.
- R8: If a valid sample arrives on a channel in the same cycle that channel is read, the read returns the peak held before that sample. The channel then restarts with that sample's magnitude.
- R9: The read-data word updates on the clock edge that samples the read strobe and holds its value while the strobe is low. A read of an address outside BASE_ADDR..BASE_ADDR+3 returns 0 and clears nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sample_i | input | N_CH*SAMPLE_W | Packed signed samples, channel i in bits [i*SAMPLE_W +: SAMPLE_W] |
| valid_i | input | N_CH | Per-channel sample strobe |
| rd_en_i | input | 1 | Register read strobe |
| rd_addr_i | input | ADDR_W | Register read address |
| rd_data_o | output | CODE_W | Level word of the last read |

## Verification
The bench builds the meter with four 24-bit channels, a 4-bit address space and the channel window based at 8. With that base there are unmapped addresses both below and above the four channel registers, so misses on either side can be tested. The 24-bit width makes the exact most negative sample and full scale easy to reach. The bench places the test levels half a decibel inside a step, so each expected code follows directly from the level in tenths of a dB. Directed runs cover the comparator floor, a sample and a read of the same channel in one cycle, and whether one channel's read disturbs another channel.

// File: rtl/plm_pkg.sv
package plm_pkg;

    // 10^(-1/20) in unsigned Q0.32, the ratio between two adjacent 1 dB steps
    localparam longint unsigned DB_STEP_Q32 = 64'd3827893631;
    localparam longint unsigned Q32_HALF    = 64'h0000_0000_8000_0000;

    // Threshold for an attenuation of att_db whole decibels below the
    // full-scale magnitude of a mag_w-bit unsigned value.
    function automatic longint unsigned db_threshold(input int unsigned att_db,
                                                     input int unsigned mag_w);
        longint unsigned level;
        level = (64'd1 << mag_w) - 64'd1;
        for (int unsigned step = 0; step < att_db; step++) begin
            level = (level * DB_STEP_Q32 + Q32_HALF) >> 32;
        end
        return level;
    endfunction

    function automatic int unsigned count_width(input int unsigned max_value);
        return $clog2(max_value + 2);
    endfunction

endpackage

// File: rtl/plm_magnitude.sv
module plm_magnitude #(
    parameter int SAMPLE_W = 24,
    localparam int MAG_W   = SAMPLE_W - 1
) (
    input  logic [SAMPLE_W-1:0] sample_i,
    output logic [MAG_W-1:0]    mag_o
);

    logic [SAMPLE_W-1:0] negated;

    always_comb begin
        negated = (~sample_i) + SAMPLE_W'(1);
        if (!sample_i[SAMPLE_W-1]) begin
            mag_o = sample_i[MAG_W-1:0];
        end else if (negated[SAMPLE_W-1]) begin
            // only the sign bit set: its true magnitude does not fit, clamp
            mag_o = '1;
        end else begin
            mag_o = negated[MAG_W-1:0];
        end
    end

endmodule

// File: rtl/plm_channel.sv
module plm_channel #(
    parameter int SAMPLE_W = 24,
    localparam int MAG_W   = SAMPLE_W - 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [SAMPLE_W-1:0] sample_i,
    input  logic                valid_i,
    input  logic                clear_i,
    output logic [MAG_W-1:0]    peak_o
);

    typedef struct packed {
        logic [MAG_W-1:0] peak;
    } chan_state_t;

    chan_state_t      state_d, state_q;
    logic [MAG_W-1:0] mag;

    plm_magnitude #(
        .SAMPLE_W (SAMPLE_W)
    ) u_magnitude (
        .sample_i (sample_i),
        .mag_o    (mag)
    );

    always_comb begin
        state_d = state_q;
        if (clear_i) begin
            // restart; a sample landing with the read seeds the new window
            state_d.peak = valid_i ? mag : '0;
        end else if (valid_i && (mag > state_q.peak)) begin
            state_d.peak = mag;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign peak_o = state_q.peak;

    assert_peak_captured_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && !clear_i) |=> (state_q.peak >= $past(mag)));

    assert_peak_no_decay_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !clear_i |=> (state_q.peak >= $past(state_q.peak)));

    assert_clear_on_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (clear_i && !valid_i) |=> (state_q.peak == '0));

    assert_read_seeds_sample_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (clear_i && valid_i) |=> (state_q.peak == $past(mag)));

endmodule

// File: rtl/plm_db_ladder.sv
module plm_db_ladder #(
    parameter int MAG_W   = 23,
    parameter int DB_SPAN = 60,
    parameter int CODE_W  = 10,
    localparam int CNT_W  = plm_pkg::count_width(DB_SPAN)
) (
    input  logic [MAG_W-1:0]  peak_i,
    output logic [CODE_W-1:0] code_o
);

    logic [DB_SPAN:0] below;
    logic [CNT_W-1:0] depth;

    for (genvar k = 0; k <= DB_SPAN; k++) begin : g_rung
        localparam longint unsigned THRESH = plm_pkg::db_threshold(k, MAG_W);
        assign below[k] = (peak_i < MAG_W'(THRESH));
    end

    always_comb begin
        depth = '0;
        for (int k = 0; k <= DB_SPAN; k++) begin
            depth = depth + CNT_W'(below[k]);
        end
        if (depth > CNT_W'(DB_SPAN)) begin
            code_o = CODE_W'(DB_SPAN);
        end else begin
            code_o = CODE_W'(depth);
        end
    end

endmodule

// File: rtl/peak_level_meter.sv
module peak_level_meter #(
    parameter int N_CH      = 4,
    parameter int SAMPLE_W  = 24,
    parameter int ADDR_W    = 4,
    parameter int BASE_ADDR = 8,
    parameter int CODE_W    = 10,
    parameter int DB_SPAN   = 60
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [N_CH*SAMPLE_W-1:0] sample_i,
    input  logic [N_CH-1:0]          valid_i,
    input  logic                     rd_en_i,
    input  logic [ADDR_W-1:0]        rd_addr_i,
    output logic [CODE_W-1:0]        rd_data_o
);

    localparam int MAG_W = SAMPLE_W - 1;
    localparam int SEL_W = (N_CH > 1) ? $clog2(N_CH) : 1;
    localparam int CMP_W = ADDR_W + 1;

    typedef struct packed {
        logic [CODE_W-1:0] data;
    } rd_state_t;

    rd_state_t         rd_d, rd_q;
    logic [MAG_W-1:0]  peak_arr [N_CH];
    logic [N_CH-1:0]   clear;
    logic              hit;
    logic [ADDR_W-1:0] offset;
    logic [SEL_W-1:0]  sel;
    logic [MAG_W-1:0]  sel_peak;
    logic [CODE_W-1:0] sel_code;

    always_comb begin
        offset = rd_addr_i - ADDR_W'(BASE_ADDR);
        sel    = SEL_W'(offset);
        hit    = ({1'b0, rd_addr_i} >= CMP_W'(BASE_ADDR)) &&
                 ({1'b0, rd_addr_i} <  CMP_W'(BASE_ADDR + N_CH));
    end

    for (genvar ch = 0; ch < N_CH; ch++) begin : g_chan
        assign clear[ch] = rd_en_i && hit && (sel == SEL_W'(ch));

        plm_channel #(
            .SAMPLE_W (SAMPLE_W)
        ) u_channel (
            .clk      (clk),
            .rst_n    (rst_n),
            .sample_i (sample_i[ch*SAMPLE_W +: SAMPLE_W]),
            .valid_i  (valid_i[ch]),
            .clear_i  (clear[ch]),
            .peak_o   (peak_arr[ch])
        );
    end

    always_comb begin
        sel_peak = '0;
        for (int ch = 0; ch < N_CH; ch++) begin
            if (sel == SEL_W'(ch)) begin
                sel_peak = peak_arr[ch];
            end
        end
    end

    // one shared ladder behind the channel mux
    plm_db_ladder #(
        .MAG_W   (MAG_W),
        .DB_SPAN (DB_SPAN),
        .CODE_W  (CODE_W)
    ) u_ladder (
        .peak_i (sel_peak),
        .code_o (sel_code)
    );

    always_comb begin
        rd_d = rd_q;
        if (rd_en_i) begin
            rd_d.data = hit ? sel_code : '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_q <= '0;
        end else begin
            rd_q <= rd_d;
        end
    end

    assign rd_data_o = rd_q.data;

    assert_code_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data_o <= CODE_W'(DB_SPAN));

    assert_single_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(clear));

    assert_unmapped_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en_i && !hit) |=> (rd_data_o == '0));

    assert_data_holds_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en_i |=> $stable(rd_data_o));

endmodule

// File: tb/peak_level_meter_bench.sv
`timescale 1ns/1ps
module peak_level_meter_bench;

    localparam int N_CH   = 4;
    localparam int SW     = 24;
    localparam int AW     = 4;
    localparam int BASE   = 8;
    localparam int CW     = 10;
    localparam int FLOOR  = 60;

    localparam int N_VEC = 8;
    localparam int VEC_CH  [N_VEC] = '{0, 1, 2, 3, 0, 1, 2, 3};
    localparam int VEC_ATT [N_VEC] = '{0, 5, 65, 205, 395, 595, 700, 125};
    localparam int VEC_NEG [N_VEC] = '{0, 0, 1, 0, 1, 0, 0, 1};

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic [N_CH*SW-1:0] sample = '0;
    logic [N_CH-1:0]    valid = '0;
    logic               rd_en = 1'b0;
    logic [AW-1:0]      rd_addr = '0;
    logic [CW-1:0]      rd_data;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    peak_level_meter #(
        .N_CH      (N_CH),
        .SAMPLE_W  (SW),
        .ADDR_W    (AW),
        .BASE_ADDR (BASE),
        .CODE_W    (CW),
        .DB_SPAN   (FLOOR)
    ) u_peak_level_meter (
        .clk       (clk),
        .rst_n     (rst_n),
        .sample_i  (sample),
        .valid_i   (valid),
        .rd_en_i   (rd_en),
        .rd_addr_i (rd_addr),
        .rd_data_o (rd_data)
    );

    // sample value at att_tenths tenths of a dB below full scale
    function automatic int level_amp(input int att_tenths);
        real fs;
        fs = (2.0 ** (SW - 1)) - 1.0;
        return int'(fs * (10.0 ** (-att_tenths / 200.0)));
    endfunction

    function automatic int expected_code(input int att_tenths);
        int c;
        c = (att_tenths + 9) / 10;
        return (c > FLOOR) ? FLOOR : c;
    endfunction

    task automatic check(input string req, input int got, input int exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s: got %0d expected %0d", req, got, exp);
        end
    endtask

    task automatic push(input int ch, input int value);
        @(negedge clk);
        sample[ch*SW +: SW] = SW'(value);
        valid[ch] = 1'b1;
        @(negedge clk);
        valid[ch] = 1'b0;
    endtask

    task automatic read_addr(input int addr, output int value);
        @(negedge clk);
        rd_en = 1'b1;
        rd_addr = AW'(addr);
        @(negedge clk);
        rd_en = 1'b0;
        value = int'(rd_data);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        check("R1 rd_data after reset", int'(rd_data), 0);
        for (int ch = 0; ch < N_CH; ch++) begin
            read_addr(BASE + ch, v);
            check("R1 empty peak reads floor", v, FLOOR);
        end

        // R5/R6: table of levels walked by one loop
        for (int i = 0; i < N_VEC; i++) begin
            int amp;
            amp = level_amp(VEC_ATT[i]);
            if (VEC_NEG[i] != 0) amp = -amp;
            push(VEC_CH[i], amp);
            read_addr(BASE + VEC_CH[i], v);
            check("R5 R6 level code", v, expected_code(VEC_ATT[i]));
        end

        // R7: most negative sample clamps to full scale
        push(3, -(1 <<< (SW - 1)));
        read_addr(BASE + 3, v);
        check("R7 most negative sample", v, 0);

        // R3: smaller later samples do not lower the held peak
        push(2, level_amp(155));
        push(2, level_amp(405));
        push(2, -level_amp(255));
        read_addr(BASE + 2, v);
        check("R3 peak held", v, expected_code(155));

        // R4: the read cleared the channel
        read_addr(BASE + 2, v);
        check("R4 cleared after read", v, FLOOR);

        // R4: reading one channel leaves another untouched
        push(0, level_amp(45));
        push(3, level_amp(505));
        read_addr(BASE + 0, v);
        check("R4 first channel", v, expected_code(45));
        read_addr(BASE + 3, v);
        check("R4 other channel kept", v, expected_code(505));

        // R9: unmapped addresses read 0 and clear nothing; data holds
        push(2, level_amp(25));
        read_addr(3, v);
        check("R9 unmapped below", v, 0);
        read_addr(BASE + 3, v);
        check("R9 empty channel", v, FLOOR);
        read_addr(BASE + N_CH + 1, v);
        check("R9 unmapped above", v, 0);
        read_addr(BASE + 2, v);
        check("R9 peak survived unmapped reads", v, expected_code(25));
        repeat (3) @(negedge clk);
        check("R9 data holds without strobe", int'(rd_data), expected_code(25));

        // R2: samples with valid low are ignored
        @(negedge clk);
        sample[1*SW +: SW] = SW'(level_amp(0));
        repeat (2) @(negedge clk);
        read_addr(BASE + 1, v);
        check("R2 valid low ignored", v, FLOOR);

        // R2: a constant positive offset is metered raw
        for (int n = 0; n < 6; n++) push(0, level_amp(185));
        read_addr(BASE + 0, v);
        check("R2 constant offset metered", v, expected_code(185));

        // R8: sample and read on the same channel in one cycle
        push(1, level_amp(95));
        @(negedge clk);
        rd_en = 1'b1;
        rd_addr = AW'(BASE + 1);
        sample[1*SW +: SW] = SW'(level_amp(305));
        valid[1] = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
        valid[1] = 1'b0;
        check("R8 read returns prior peak", int'(rd_data), expected_code(95));
        read_addr(BASE + 1, v);
        check("R8 same-cycle sample kept", v, expected_code(305));

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule